// File: doc/BRIEF.md
# Up/Down and Center-Aligned Timer Counter

This block is the counting core of a general-purpose timer. A control register chooses between edge-aligned counting (up or down) and three center-aligned modes, where the counter rises and falls in a triangle. An auto-reload register sets the period. Writes to it can take effect at once, or they can wait in a shadow copy until the next update event. A one-shot option lets the counter stop itself at its first update event. A 2-bit division code is stored and sent out as a sampling-period ratio for filters in a neighbouring block.

One compare channel watches the counter. It raises a sticky flag, and in center-aligned modes the flag is restricted to the counting phase that the mode selects. All registers sit behind a single-cycle 16-bit write port with a combinational read port.

Top module: `updn_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the counter is 0, the compare flag is 0, no update event is signalled and the division ratio output is 1.
- R2: Control register layout (address 0): bit 0 run, bit 1 one-shot, bit 2 direction (1 = down), bits 4:3 alignment mode, bit 5 reload buffering, bits 7:6 division code. Bits 15:8 always read as zero.
- R3: Division code 00, 01 and 10 drive a ratio of 1, 2 and 4. The reserved code 11 drives 0.
- R4: Reload register at address 2. With buffering off, a write changes the active period at once. With buffering on, a write is held and copied into the active period on the next update event. Reads return the active period.
- R5: In mode 00 counting up, the counter steps by one. From the reload value it wraps to 0, and update is high in the cycle the counter equals the reload value.
- R6: In mode 00 counting down, the counter steps down. From 0 it reloads the reload value, and update is high in the cycle the counter is 0.
- R7: In modes 01, 10 and 11 the counter rises from 0 to the reload value and then falls back to 0. Update is high at the top turn and at the bottom turn.
- R8: In modes 01, 10 and 11 the direction bit reads back the hardware counting phase, and writes to it are ignored.
- R9: The compare value is at address 3 and the status register is at address 4, where bit 0 is the flag. A running match sets the flag: only while falling in mode 01, only while rising in mode 10, and in either phase in modes 11 and 00. The flag stays set until a write puts 0 in status bit 0. Writing 1 has no effect.
- R10: While the counter runs in mode 00, a control write that selects a nonzero mode is discarded as a whole.
- R11: With one-shot set, the run bit clears at the update event and the counter holds. With one-shot clear, counting continues through update events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cnt_o | output | 16 | Counter value |
| upd_o | output | 1 | Update event, high in the turning cycle |
| cmp_flag_o | output | 1 | Sticky compare flag |
| run_o | output | 1 | Counter enable state |
| div_ratio_o | output | 3 | Filter sampling ratio |

## Verification
The bench aims at the turning points:
- The top and bottom of the triangle. A design that flipped its phase one cycle late would overshoot the reload value.
- The compare value placed where the counter passes it in both phases. A design that ignored the mode's phase rule would set the flag on the wrong half of the triangle.

It writes the buffered reload value mid-period. An immediate copy shows up on the reload readback before the update event.

It attempts a switch to a center-aligned mode while the counter runs. A design that accepted it would change both the readback mode and the counting pattern.

One-shot runs must leave the run bit low and the counter frozen after the wrap.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  typedef enum logic [1:0] {
    ALN_EDGE  = 2'b00,
    ALN_CDN   = 2'b01,
    ALN_CUP   = 2'b10,
    ALN_CBOTH = 2'b11
  } align_e;

  typedef struct packed {
    logic [1:0] div;
    logic       buffered;
    align_e     mode;
    logic       dn;
    logic       one_shot;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = 8;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_ARR  = 3'd2;
  localparam logic [2:0] A_CMP  = 3'd3;
  localparam logic [2:0] A_STS  = 3'd4;
endpackage

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          stop_i,
  output ctrl_t         ctrl_o
);
  ctrl_t ctrl_q;
  logic  blocked;

  // edge -> center switch forbidden while running
  assign blocked = ctrl_q.run && (ctrl_q.mode == ALN_EDGE) && (wdata_i[4:3] != 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (wr_i && !blocked)  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    else if (stop_i)            ctrl_q.run <= 1'b0;
  end

  assign ctrl_o = ctrl_q;

  p_center_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && ctrl_q.mode == ALN_EDGE) |=> (ctrl_q.mode == ALN_EDGE));

  p_one_shot_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_i) |=> !ctrl_q.run);
endmodule

// File: rtl/updn_timer_cnt.sv
module updn_timer_cnt
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  align_e           mode_i,
  input  logic             dn_i,
  input  logic             buf_i,
  input  logic             wr_cnt_i,
  input  logic             wr_arr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_o,
  output logic             hdn_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, arr_q, pre_q;
  logic             hdn_q, hdn_d, upd;
  logic             arr_zero;

  assign arr_zero = (arr_q == '0);

  always_comb begin
    if (mode_i == ALN_EDGE) upd = dn_i ? (cnt_q == '0) : (cnt_q == arr_q);
    else                    upd = hdn_q ? (cnt_q == '0) : (cnt_q >= arr_q);
    upd = upd & run_i;

    hdn_d = hdn_q;
    if (mode_i == ALN_EDGE) hdn_d = dn_i;
    else if (upd)           hdn_d = ~hdn_q;

    cnt_d = cnt_q;
    if (run_i) begin
      if (mode_i == ALN_EDGE) begin
        if (!dn_i) cnt_d = upd ? '0 : cnt_q + ONE;
        else       cnt_d = upd ? arr_q : cnt_q - ONE;
      end else if (!hdn_q) begin
        cnt_d = upd ? (arr_zero ? '0 : cnt_q - ONE) : cnt_q + ONE;
      end else begin
        cnt_d = upd ? (arr_zero ? '0 : cnt_q + ONE) : cnt_q - ONE;
      end
    end
    if (wr_cnt_i) cnt_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hdn_q <= 1'b0;
      arr_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      hdn_q <= hdn_d;
      if (wr_arr_i) pre_q <= wdata_i;
      if (wr_arr_i && !buf_i) arr_q <= wdata_i;
      else if (upd && buf_i)  arr_q <= pre_q;
    end
  end

  assign cnt_o = cnt_q;
  assign arr_o = arr_q;
  assign hdn_o = hdn_q;
  assign upd_o = upd;

  p_edge_up_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == ALN_EDGE && !dn_i && cnt_q == arr_q && !wr_cnt_i) |=> (cnt_q == '0));

  p_edge_dn_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == ALN_EDGE && dn_i && cnt_q == '0 && !wr_cnt_i) |=> (cnt_q == $past(arr_q)));

  p_preload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && buf_i && !wr_arr_i) |=> (arr_q == $past(pre_q)));

  p_hold_stopped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/updn_timer_cmp.sv
module updn_timer_cmp
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  align_e           mode_i,
  input  logic             hdn_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_ccr_i,
  input  logic             wr_sts_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] ccr_q;
  logic             flag_q, phase_ok, hit, clr;

  always_comb begin
    unique case (mode_i)
      ALN_CDN: phase_ok = hdn_i;
      ALN_CUP: phase_ok = ~hdn_i;
      default: phase_ok = 1'b1;
    endcase
  end

  assign hit = run_i && (cnt_i == ccr_q) && phase_ok;
  assign clr = wr_sts_i && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ccr_i) ccr_q <= wdata_i;
      flag_q <= hit | (flag_q & ~clr);
    end
  end

  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;

  p_cup_no_down_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ALN_CUP && hdn_i && !flag_q) |=> !flag_q);

  p_cdn_no_up_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ALN_CDN && !hdn_i && !flag_q) |=> !flag_q);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !wr_sts_i) |=> flag_q);
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             cmp_flag_o,
  output logic             run_o,
  output logic [2:0]       div_ratio_o
);
  localparam int PAD_W = CNT_W - CTRL_W;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, arr, ccr;
  logic             hdn, upd, flag, dir_rd;

  updn_timer_ctrl #(.DW(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && addr_i == A_CTRL),
    .wdata_i (wdata_i),
    .stop_i  (upd && ctrl.one_shot),
    .ctrl_o  (ctrl)
  );

  updn_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .mode_i   (ctrl.mode),
    .dn_i     (ctrl.dn),
    .buf_i    (ctrl.buffered),
    .wr_cnt_i (we_i && addr_i == A_CNT),
    .wr_arr_i (we_i && addr_i == A_ARR),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .arr_o    (arr),
    .hdn_o    (hdn),
    .upd_o    (upd)
  );

  updn_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .mode_i   (ctrl.mode),
    .hdn_i    (hdn),
    .cnt_i    (cnt),
    .wr_ccr_i (we_i && addr_i == A_CMP),
    .wr_sts_i (we_i && addr_i == A_STS),
    .wdata_i  (wdata_i),
    .ccr_o    (ccr),
    .flag_o   (flag)
  );

  assign dir_rd = (ctrl.mode == ALN_EDGE) ? ctrl.dn : hdn;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{PAD_W{1'b0}}, ctrl.div, ctrl.buffered, ctrl.mode,
                          dir_rd, ctrl.one_shot, ctrl.run};
      A_CNT:   rdata_o = cnt;
      A_ARR:   rdata_o = arr;
      A_CMP:   rdata_o = ccr;
      A_STS:   rdata_o = {{(CNT_W-1){1'b0}}, flag};
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.div)
      2'b00:   div_ratio_o = 3'd1;
      2'b01:   div_ratio_o = 3'd2;
      2'b10:   div_ratio_o = 3'd4;
      default: div_ratio_o = 3'd0;
    endcase
  end

  assign cnt_o      = cnt;
  assign upd_o      = upd;
  assign cmp_flag_o = flag;
  assign run_o      = ctrl.run;

  p_center_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.run && ctrl.mode != ALN_EDGE && cnt < arr && !we_i) |=> (cnt <= arr));
endmodule

// File: tb/updn_timer_tb_top.sv
module updn_timer_tb_top;
  localparam int W = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_ARR = 3'd2, A_CMP = 3'd3, A_STS = 3'd4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, we;
  logic [2:0] addr;
  logic [W-1:0] wdata, rdata, cnt_o;
  logic upd_o, flag_o, run_o;
  logic [2:0] div_o;

  updn_timer #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_o(cnt_o), .upd_o(upd_o), .cmp_flag_o(flag_o),
    .run_o(run_o), .div_ratio_o(div_o)
  );

  int total = 0, bad = 0;
  string req = "R1";

  // reference model state
  logic [W-1:0] m_cnt, m_arr, m_pre, m_ccr;
  logic m_flag, m_hdn, m_run, m_os, m_dn, m_buf;
  logic [1:0] m_mode, m_div;

  function automatic logic m_upd();
    logic u;
    if (m_mode == 2'b00) u = m_dn ? (m_cnt == 0) : (m_cnt == m_arr);
    else                 u = m_hdn ? (m_cnt == 0) : (m_cnt >= m_arr);
    return u & m_run;
  endfunction

  function automatic logic [W-1:0] m_rd(input logic [2:0] a);
    case (a)
      A_CTRL:  return {8'h00, m_div, m_buf, m_mode, (m_mode == 2'b00) ? m_dn : m_hdn, m_os, m_run};
      A_CNT:   return m_cnt;
      A_ARR:   return m_arr;
      A_CMP:   return m_ccr;
      A_STS:   return {15'd0, m_flag};
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] m_ratio();
    return (m_div == 2'b11) ? 3'd0 : 3'(1 << m_div);
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_arr = 0; m_pre = 0; m_ccr = 0; m_flag = 0; m_hdn = 0;
    m_run = 0; m_os = 0; m_dn = 0; m_buf = 0; m_mode = 0; m_div = 0;
  endtask

  task automatic m_step(input logic w, input logic [2:0] a, input logic [W-1:0] d);
    logic u, hit, blk;
    logic [W-1:0] nc, na;
    logic nh;
    u   = m_upd();
    hit = m_run && (m_cnt == m_ccr) &&
          ((m_mode == 2'b01) ? m_hdn : (m_mode == 2'b10) ? !m_hdn : 1'b1);
    nh = m_hdn;
    if (m_mode == 2'b00) nh = m_dn;
    else if (u)          nh = !m_hdn;
    nc = m_cnt;
    if (m_run) begin
      if (m_mode == 2'b00) nc = !m_dn ? (u ? '0 : m_cnt + 1) : (u ? m_arr : m_cnt - 1);
      else if (!m_hdn)     nc = u ? ((m_arr == 0) ? '0 : m_cnt - 1) : m_cnt + 1;
      else                 nc = u ? ((m_arr == 0) ? '0 : m_cnt + 1) : m_cnt - 1;
    end
    if (w && a == A_CNT) nc = d;
    na = m_arr;
    if (w && a == A_ARR && !m_buf) na = d;
    else if (u && m_buf)           na = m_pre;
    if (w && a == A_ARR) m_pre = d;
    m_flag = hit | (m_flag & !(w && a == A_STS && !d[0]));
    if (w && a == A_CMP) m_ccr = d;
    blk = m_run && m_mode == 2'b00 && d[4:3] != 2'b00;
    if (w && a == A_CTRL && !blk) begin
      {m_div, m_buf, m_mode, m_dn, m_os, m_run} = d[7:0];
    end else if (u && m_os) m_run = 1'b0;
    m_cnt = nc; m_arr = na; m_hdn = nh;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, advance
  task automatic cyc(input logic w, input logic [2:0] a, input logic [W-1:0] d);
    we = w; addr = a; wdata = d;
    #1;
    chk(req, cnt_o, m_cnt, "cnt");
    chk(req, upd_o, m_upd(), "upd");
    chk(req, flag_o, m_flag, "flag");
    chk(req, run_o, m_run, "run");
    chk(req, div_o, m_ratio(), "div");
    if (!w) chk(req, rdata, m_rd(a), "rdata");
    @(posedge clk);
    m_step(w, a, d);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, '0);
  endtask

  task automatic wctrl(input logic run, input logic os, input logic dn, input logic [1:0] mode,
                       input logic bufd, input logic [1:0] div);
    cyc(1'b1, A_CTRL, {8'h00, div, bufd, mode, dn, os, run});
  endtask

  task automatic stop_all();
    wctrl(1'b0, m_os, m_dn, m_mode, m_buf, m_div);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; we = 1'b0; addr = A_CTRL; wdata = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    req = "R1";
    #1;
    chk("R1", rdata, 16'h0000, "ctrl reset");
    chk("R1", cnt_o, 0, "cnt reset");
    chk("R1", flag_o, 0, "flag reset");
    chk("R1", upd_o, 0, "upd reset");
    chk("R1", div_o, 1, "ratio reset");
    @(negedge clk);

    // R2 upper bits read zero
    req = "R2";
    cyc(1'b1, A_CTRL, 16'hFF00);
    cyc(1'b0, A_CTRL, 0);
    #1 chk("R2", rdata, 16'h0000, "ctrl upper bits");

    // R3 division ratios
    req = "R3";
    for (int c = 0; c < 4; c++) begin
      wctrl(0, 0, 0, 2'b00, 0, 2'(c));
      #1 chk("R3", div_o, (c == 3) ? 0 : (1 << c), "ratio");
    end
    wctrl(0, 0, 0, 2'b00, 0, 2'b00);

    // R5 edge up wrap
    req = "R5";
    cyc(1, A_ARR, 3); cyc(1, A_CNT, 0);
    wctrl(1, 0, 0, 2'b00, 0, 0);
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R5", cnt_o, i % 4, "up seq");
      chk("R5", upd_o, (i % 4) == 3, "up upd");
      cyc(0, A_CNT, 0);
    end
    stop_all();

    // R6 edge down reload
    req = "R6";
    cyc(1, A_CNT, 2);
    wctrl(1, 0, 1, 2'b00, 0, 0);
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R6", cnt_o, (i < 3) ? 2 - i : 3 - ((i - 3) % 4), "down seq");
      chk("R6", upd_o, cnt_o == 0, "down upd");
      cyc(0, A_CTRL, 0);
    end
    stop_all();

    // R7/R8 center triangle, hardware direction
    req = "R7";
    wctrl(0, 0, 0, 2'b00, 0, 0);
    cyc(1, A_CNT, 0);
    wctrl(0, 0, 0, 2'b11, 0, 0);
    wctrl(1, 0, 0, 2'b11, 0, 0);
    for (int i = 0; i < 12; i++) begin
      int ph;
      ph = i % 6;
      #1;
      chk("R7", cnt_o, (ph <= 3) ? ph : 6 - ph, "triangle");
      chk("R7", upd_o, ph == 3 || (ph == 0 && i > 0), "turn upd");
      chk("R8", rdata[2], (ph >= 4) || (ph == 0 && i > 0), "hw dir");
      cyc(0, A_CTRL, 0);
    end
    req = "R8";
    wctrl(1, 0, ~m_hdn, 2'b11, 0, 0);
    idle(6, A_CTRL);
    stop_all();

    // R9 phase rules and sticky flag
    req = "R9";
    for (int md = 1; md < 4; md++) begin
      wctrl(0, 0, 0, 2'b00, 0, 0);
      cyc(1, A_ARR, 4); cyc(1, A_CMP, 2); cyc(1, A_CNT, 0); cyc(1, A_STS, 0);
      wctrl(0, 0, 0, 2'(md), 0, 0);
      wctrl(1, 0, 0, 2'(md), 0, 0);
      idle(4, A_STS);
      #1 chk("R9", flag_o, md != 1, "after rising pass");
      idle(4, A_STS);
      #1 chk("R9", flag_o, 1, "after falling pass");
      stop_all();
      cyc(1, A_STS, 1);
      #1 chk("R9", flag_o, 1, "write 1 keeps flag");
      cyc(1, A_STS, 0);
      #1 chk("R9", flag_o, 0, "write 0 clears");
    end

    // R10 forbidden edge->center while running
    req = "R10";
    wctrl(0, 0, 0, 2'b00, 0, 0);
    cyc(1, A_ARR, 9); cyc(1, A_CNT, 0);
    wctrl(1, 0, 0, 2'b00, 0, 0);
    wctrl(1, 0, 0, 2'b01, 0, 0);
    cyc(0, A_CTRL, 0);
    #1 chk("R10", rdata[4:3], 0, "mode kept");
    idle(10, A_CNT);

    // R4 buffered reload
    req = "R4";
    stop_all();
    cyc(1, A_ARR, 5); cyc(1, A_CNT, 0);
    wctrl(1, 0, 0, 2'b00, 1, 0);
    cyc(1, A_ARR, 2);
    cyc(0, A_ARR, 0);
    #1 chk("R4", rdata, 5, "buffered held");
    idle(4, A_ARR);
    #1 chk("R4", rdata, 2, "buffered moved");
    stop_all();
    wctrl(0, 0, 0, 2'b00, 0, 0);
    cyc(1, A_ARR, 7);
    cyc(0, A_ARR, 0);
    #1 chk("R4", rdata, 7, "immediate");

    // R11 one-shot
    req = "R11";
    cyc(1, A_ARR, 2); cyc(1, A_CNT, 0);
    wctrl(1, 1, 0, 2'b00, 0, 0);
    idle(6, A_CNT);
    #1;
    chk("R11", run_o, 0, "stopped");
    chk("R11", cnt_o, 0, "held at 0");

    // random mix checked against the model
    req = "R9";
    for (int it = 0; it < 40; it++) begin
      logic [W-1:0] ar;
      stop_all();
      ar = W'(1 + $urandom % 12);
      cyc(1, A_ARR, ar);
      cyc(1, A_CNT, W'($urandom % (ar + 1)));
      cyc(1, A_CMP, W'($urandom % (ar + 1)));
      cyc(1, A_STS, 0);
      wctrl(0, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom));
      wctrl(1, m_os, m_dn, m_mode, m_buf, m_div);
      for (int k = 0; k < 30; k++) begin
        int r;
        r = $urandom % 20;
        if (r == 0)      cyc(1, A_ARR, W'(1 + $urandom % 12));
        else if (r == 1) cyc(1, A_STS, W'($urandom % 2));
        else if (r == 2) cyc(1, A_CTRL, {8'h00, 8'($urandom)});
        else             cyc(0, 3'($urandom % 5), 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule